// File: doc/BRIEF.md
# ATM Cell Receive Front End

This block sits between a UTOPIA-style PHY receive bus and the cell processing logic of a chip. It drives the active-low receive enable and, one cycle after each enabled cycle, samples start-of-cell, cell-available, the data bus and its two parity bits. Each accepted cell leaves the block as a stream of transfers. The first transfer carries a start marker, the last carries an end marker, and an error flag is reported with the end marker.

A set of static configuration inputs controls the interface. They select byte-wide or 16-bit-wide transfers, a 52-byte cell format without HEC, an optional extra leading transfer that is dropped, and whether start-of-cell must coincide with cell-available. They also select whether the enable is released while no cell is in progress and no cell is on offer. Parity is odd. A start-of-cell that arrives inside a cell abandons that cell and starts counting a new one. Configuration must only change while the receiver is idle.

Top module: `atm_rx_front`

## Requirements
- R1: While reset is held and in the first cycle after it, `phy_enb_n` is 1 and every output marker and `out_valid` are 0.
- R2: A transfer is taken only at a clock edge whose previous cycle had `phy_enb_n` low. The data of a taken transfer appears on `out_data` with `out_valid` in the cycle after that edge.
- R3: In byte mode (`cfg_wide`=0) a cell is 53 transfers. In 16-bit mode (`cfg_wide`=1) a cell is 27 transfers. `out_sop` marks the first delivered transfer and `out_eop` marks the last one.
- R4: With `cfg_cell52`=1 a cell is 52 transfers in byte mode and 26 transfers in 16-bit mode.
- R5: With `cfg_extra_hdr`=1 one more transfer is taken at the head of every cell. That transfer is never delivered, so `out_sop` falls on the second transfer taken.
- R6: With `cfg_soc_gate`=1 a `phy_soc` is honoured only if `phy_clav` is 1 at the same sampling edge.
- R7: With `cfg_idle_enb_off`=1, `phy_enb_n` is 1 whenever no cell is in progress and `phy_clav` was 0 at the previous edge. With it at 0, the enable stays active. The enable is always active while a cell is in progress.
- R8: In byte mode the parity is odd over `phy_data[7:0]` and `phy_par[0]`.
- R9: In 16-bit mode with `cfg_par16`=1, the parity is odd over all 16 data bits and `phy_par[1]`, and `phy_par[0]` is ignored.
- R10: In 16-bit mode with `cfg_par16`=0, `phy_par[0]` gives odd parity for the low byte and `phy_par[1]` gives odd parity for the high byte.
- R11: Any parity error in a cell, including one on a dropped head transfer, sets `out_err` together with that cell's `out_eop`. `out_err` is never 1 without `out_eop`.
- R12: A honoured start-of-cell inside a cell pulses `out_abort` for one cycle. The old cell gets no `out_eop`, and the new cell is counted from its first transfer.
- R13: Transfers taken while no cell is in progress and without a honoured start-of-cell produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 selects 16-bit transfers |
| cfg_par16 | input | 1 | One parity over 16 bits in 16-bit mode (tie to 1 by default) |
| cfg_cell52 | input | 1 | Cells without HEC byte |
| cfg_extra_hdr | input | 1 | Drop one extra leading transfer per cell |
| cfg_soc_gate | input | 1 | Start-of-cell needs cell-available |
| cfg_idle_enb_off | input | 1 | Release enable while idle and no cell offered |
| phy_enb_n | output | 1 | Active-low receive enable to the PHY |
| phy_soc | input | 1 | Start-of-cell from the PHY |
| phy_clav | input | 1 | Cell-available from the PHY |
| phy_data | input | 16 | Receive data (low byte only in byte mode) |
| phy_par | input | 2 | Receive parity bits |
| out_valid | output | 1 | Delivered transfer valid |
| out_data | output | 16 | Delivered transfer |
| out_sop | output | 1 | First transfer of a cell |
| out_eop | output | 1 | Last transfer of a cell |
| out_err | output | 1 | Cell had a parity error (with `out_eop`) |
| out_abort | output | 1 | Previous cell abandoned by a new start-of-cell |

## Verification
On every cycle the assertions check several rules. Markers never appear without a valid transfer. Nothing is delivered unless the enable was active two cycles earlier. The error flag only rides with an end marker, and the count of transfers from start to end marker matches the configured length. The released enable in the idle state is also checked on every cycle. The bench scenarios show what the assertions cannot: that parity is computed over the right bits in each mode, that the dropped head transfer is really the first one, that an unqualified start-of-cell is ignored, and that a mid-cell restart loses the old cell and delivers the new one complete.

// File: rtl/atm_rx_front.sv
module atm_rx_front #(
  parameter int DW         = 16,
  parameter int CELL_BYTES = 53
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wide,
  input  logic          cfg_par16,
  input  logic          cfg_cell52,
  input  logic          cfg_extra_hdr,
  input  logic          cfg_soc_gate,
  input  logic          cfg_idle_enb_off,
  output logic          phy_enb_n,
  input  logic          phy_soc,
  input  logic          phy_clav,
  input  logic [DW-1:0] phy_data,
  input  logic [1:0]    phy_par,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_err,
  output logic          out_abort
);

  localparam int CW = $clog2(CELL_BYTES + 2);
  localparam logic [CW-1:0] N_BYTE   = CW'(CELL_BYTES);
  localparam logic [CW-1:0] N_BYTE52 = CW'(CELL_BYTES - 1);
  localparam logic [CW-1:0] N_WORD   = CW'((CELL_BYTES + 1) / 2);
  localparam logic [CW-1:0] N_WORD52 = CW'(CELL_BYTES / 2);
  localparam int HB = DW / 2;

  logic          en_q, smp_q, busy;
  logic [CW-1:0] idx;
  logic          err_q;

  logic [CW-1:0] base_len, len, extra_w, cur_idx;
  logic          soc_ok, take, is_last, emit, par_bad, err_acc, busy_nx;

  assign base_len = cfg_wide ? (cfg_cell52 ? N_WORD52 : N_WORD)
                             : (cfg_cell52 ? N_BYTE52 : N_BYTE);
  assign extra_w  = CW'(cfg_extra_hdr);
  assign len      = base_len + extra_w;

  always_comb begin
    if (!cfg_wide)
      par_bad = ~^{phy_par[0], phy_data[HB-1:0]};
    else if (cfg_par16)
      par_bad = ~^{phy_par[1], phy_data};
    else
      par_bad = (~^{phy_par[0], phy_data[HB-1:0]}) | (~^{phy_par[1], phy_data[DW-1:HB]});
  end

  assign soc_ok  = phy_soc & (phy_clav | ~cfg_soc_gate);
  assign take    = smp_q & (soc_ok | busy);
  assign cur_idx = soc_ok ? '0 : idx;
  assign is_last = (cur_idx == len - 1'b1);
  assign emit    = take & ~(cfg_extra_hdr & (cur_idx == '0));
  assign err_acc = (soc_ok ? 1'b0 : err_q) | par_bad;
  assign busy_nx = take ? ~is_last : busy;

  assign phy_enb_n = ~en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      smp_q     <= 1'b0;
      busy      <= 1'b0;
      idx       <= '0;
      err_q     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_err   <= 1'b0;
      out_abort <= 1'b0;
    end else begin
      en_q      <= busy_nx | ~cfg_idle_enb_off | phy_clav;
      smp_q     <= en_q;
      busy      <= busy_nx;
      if (take) begin
        idx   <= cur_idx + 1'b1;
        err_q <= err_acc;
      end
      out_valid <= emit;
      out_data  <= phy_data;
      out_sop   <= emit & (cur_idx == extra_w);
      out_eop   <= emit & is_last;
      out_err   <= emit & is_last & err_acc;
      out_abort <= smp_q & soc_ok & busy;
    end
  end

  logic [CW-1:0] chk_cnt;
  logic          smp_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_cnt <= '0;
      smp_d   <= 1'b0;
    end else begin
      smp_d <= smp_q;
      if (out_valid) chk_cnt <= out_sop ? CW'(1) : chk_cnt + 1'b1;
    end
  end

  p_markers_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop | out_eop) |-> out_valid);

  p_err_with_eop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_eop);

  p_cell_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eop & ~out_sop) |-> (chk_cnt + 1'b1 == base_len));

  p_enable_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> smp_d);

  p_idle_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idle_enb_off & ~busy & ~phy_clav & ~(smp_q & phy_soc)) |=> phy_enb_n);

endmodule

// File: tb/tb_atm_rx_front.sv
module tb_atm_rx_front;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wide = 0, cfg_par16 = 1, cfg_cell52 = 0, cfg_extra_hdr = 0;
  logic cfg_soc_gate = 0, cfg_idle_enb_off = 0;
  logic phy_enb_n, phy_soc = 0, phy_clav = 1;
  logic [15:0] phy_data = '0;
  logic [1:0]  phy_par = '0;
  logic out_valid, out_sop, out_eop, out_err, out_abort;
  logic [15:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  atm_rx_front dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wide(cfg_wide), .cfg_par16(cfg_par16), .cfg_cell52(cfg_cell52),
    .cfg_extra_hdr(cfg_extra_hdr), .cfg_soc_gate(cfg_soc_gate),
    .cfg_idle_enb_off(cfg_idle_enb_off),
    .phy_enb_n(phy_enb_n), .phy_soc(phy_soc), .phy_clav(phy_clav),
    .phy_data(phy_data), .phy_par(phy_par),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_err(out_err), .out_abort(out_abort)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int n_valid = 0, n_cells = 0, n_abort = 0, wcnt = 0;
  int last_words = 0, last_err = 0, first_data = 0;

  always @(negedge clk) begin
    if (out_abort) n_abort++;
    if (out_valid) begin
      n_valid++;
      if (out_sop) begin wcnt = 1; first_data = int'(out_data[7:0]); end
      else wcnt++;
      if (out_eop) begin
        n_cells++;
        last_words = wcnt;
        last_err = int'(out_err);
      end
    end
  end

  task automatic drive_word(int i, bit soc, bit wide, bit par16, bit corrupt);
    logic [15:0] d;
    logic [1:0]  p;
    d = 16'(i) * 16'h0101;
    if (!wide)      p = {1'b0, ~^d[7:0]};
    else if (par16) p = {~^d, ^d[7:0]};
    else            p = {~^d[15:8], ~^d[7:0]};
    if (corrupt) begin
      if (wide && par16) p[1] = ~p[1];
      else               p[0] = ~p[0];
    end
    phy_soc  = soc;
    phy_data = d;
    phy_par  = p;
  endtask

  task automatic send_cell(bit wide, bit c52, bit extra, bit par16, int bad_idx);
    int n;
    @(negedge clk);
    cfg_wide = wide; cfg_cell52 = c52; cfg_extra_hdr = extra; cfg_par16 = par16;
    n = (wide ? (c52 ? 26 : 27) : (c52 ? 52 : 53)) + int'(extra);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      drive_word(i, i == 0, wide, par16, i == bad_idx);
    end
    @(negedge clk);
    phy_soc = 0;
    repeat (3) @(negedge clk);
  endtask

  // fields: [0] wide [1] cell52 [2] extra [3] par16 [15:8] bad index [23:16] words [24] err
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {7'd0, 1'b0, 8'd53, 8'd255, 4'd0, 4'b1000},
    {7'd0, 1'b0, 8'd52, 8'd255, 4'd0, 4'b1010},
    {7'd0, 1'b0, 8'd53, 8'd255, 4'd0, 4'b1100},
    {7'd0, 1'b1, 8'd53, 8'd7,   4'd0, 4'b1000},
    {7'd0, 1'b0, 8'd27, 8'd255, 4'd0, 4'b1001},
    {7'd0, 1'b0, 8'd26, 8'd255, 4'd0, 4'b0011},
    {7'd0, 1'b1, 8'd27, 8'd3,   4'd0, 4'b1001},
    {7'd0, 1'b1, 8'd27, 8'd20,  4'd0, 4'b0001},
    {7'd0, 1'b0, 8'd26, 8'd255, 4'd0, 4'b1111},
    {7'd0, 1'b1, 8'd53, 8'd0,   4'd0, 4'b1100}
  };

  initial begin
    int cells0, valid0, ab0;
    repeat (3) @(negedge clk);
    check("R1 enb_n in reset", int'(phy_enb_n), 1);
    check("R1 valid in reset", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after reset", int'(out_valid | out_sop | out_eop | out_err | out_abort), 0);
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] e;
      e = VEC[v];
      cells0 = n_cells;
      send_cell(e[0], e[1], e[2], e[3], int'(e[15:8]));
      check($sformatf("R3/R4/R5 cell count v%0d", v), n_cells - cells0, 1);
      check($sformatf("R3/R4 words v%0d", v), last_words, int'(e[23:16]));
      check($sformatf("R8/R9/R10/R11 err v%0d", v), last_err, int'(e[24]));
      check($sformatf("R5 first data v%0d", v), first_data, int'(e[2]));
    end

    cfg_wide = 0; cfg_cell52 = 0; cfg_extra_hdr = 0; cfg_par16 = 1;
    valid0 = n_valid;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      drive_word(i + 40, 0, 0, 1, 0);
    end
    repeat (3) @(negedge clk);
    check("R13 idle transfers ignored", n_valid - valid0, 0);

    cfg_soc_gate = 1;
    valid0 = n_valid;
    @(negedge clk);
    phy_clav = 0;
    drive_word(0, 1, 0, 1, 0);
    @(negedge clk);
    phy_clav = 1; phy_soc = 0;
    repeat (4) @(negedge clk);
    check("R6 gated soc ignored", n_valid - valid0, 0);
    cells0 = n_cells;
    send_cell(0, 0, 0, 1, 255);
    check("R6 qualified soc accepted", n_cells - cells0, 1);
    check("R6 qualified cell words", last_words, 53);
    cfg_soc_gate = 0;

    ab0 = n_abort; cells0 = n_cells;
    @(negedge clk);
    drive_word(0, 1, 0, 1, 0);
    check("R2 no output before sample", int'(out_valid), 0);
    @(negedge clk);
    check("R2 sop one cycle after sample", int'(out_valid & out_sop), 1);
    check("R2 first data", int'(out_data[7:0]), 0);
    drive_word(1, 0, 0, 1, 0);
    for (int i = 2; i < 10; i++) begin
      @(negedge clk);
      drive_word(i, 0, 0, 1, 0);
    end
    send_cell(0, 0, 0, 1, 255);
    check("R12 abort pulses", n_abort - ab0, 1);
    check("R12 only new cell ends", n_cells - cells0, 1);
    check("R12 new cell words", last_words, 53);
    check("R12 new cell err", last_err, 0);

    cfg_idle_enb_off = 1;
    phy_clav = 0;
    repeat (3) @(negedge clk);
    check("R7 enable released in idle", int'(phy_enb_n), 1);
    phy_clav = 1;
    @(negedge clk);
    check("R7 enable on cell available", int'(phy_enb_n), 0);
    cfg_idle_enb_off = 0;
    phy_clav = 0;
    repeat (2) @(negedge clk);
    check("R7 enable held without release mode", int'(phy_enb_n), 0);
    phy_clav = 1;
    repeat (2) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule